// File: doc/BRIEF.md
# Activity-Kicked Watchdog Timer

This block is a watchdog timer for a legacy PC peripheral controller. Software programs a byte-wide timeout count and picks its unit: minutes, derived by dividing a supplied one-second tick by a parameter, or whole seconds. While the count runs, selected peripheral activity reloads it. Three kinds of activity can be selected: a game-port access, a keyboard interrupt and a mouse interrupt. If no selected activity arrives before the count runs out, the timer stops. It then raises a status flag and drives the interrupt line chosen in its configuration register until software clears the flag.

A timeout can also be forced in two ways. The first is a self-clearing software command bit. The second is the rising edge of a keyboard-controller output pin, which can stay high for a long time. Only the edge fires, so a pin that stays high cannot fire the timeout twice. The timeout count, the activity configuration and the unit select sit in the main reset domain. The control/status register sits in a separate standby reset domain, so a timeout flag survives a main reset.

Top module: `evt_watchdog`

## Requirements
- R1: After both resets every register reads 0x00 and no `irqOut` bit is set.
- R2: With bit 7 of the unit register (address 3) set, the status flag stays clear after N-1 `secTick` pulses and reads 1 right after the Nth, where N is the timeout count at address 0. The counter holds at zero while the flag is set.
- R3: With bit 7 of address 3 clear, one count unit lasts 60 `secTick` pulses. A count of 2 expires on exactly the 120th pulse.
- R4: A timeout count of 0 disables expiry. The flag stays clear however many ticks arrive.
- R5: Each activity source reloads the counter with the programmed count, but only while its enable bit at address 1 is set: bit 0 for game-port access, bit 1 for keyboard, bit 2 for mouse. An activity source whose enable bit is clear has no effect.
- R6: While the flag is set, the 4-bit code in bits [7:4] of address 1 asserts `irqOut[code]`. Codes 0 and 2 assert no line. No line is ever asserted while the flag is clear.
- R7: A write to address 2 with bits 2 and 0 both 0 clears the flag, drops the interrupt line and restarts the count from the programmed value.
- R8: A write to address 2 with bit 2 set forces the flag at the next clock edge. Bit 2 always reads back 0.
- R9: When bit 3 of address 2 is set, a rising edge on `kbcForcePin` forces the flag. A pin that stays high does not force it again after a clear. With bit 3 clear, the pin has no effect.
- R10: `mainRstN` clears addresses 0, 1 and 3 but leaves address 2 intact. `standbyRstN` clears address 2.
- R11: Writing a nonzero timeout count clears the flag and loads the counter with that value.
- R12: The reserved bits read as 0. Address 1 bit 3 reads 0. Address 2 reads the flag in bit 0 and the pin enable in bit 3. Address 3 reads the unit select in bit 7 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| mainRstN | input | 1 | Main-power/system reset, active low, asynchronous |
| standbyRstN | input | 1 | Standby-power reset, active low, asynchronous |
| secTick | input | 1 | One-cycle pulse once per second |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address: 0 count, 1 config, 2 control, 3 unit |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data for `regAddr` |
| gamePortAccess | input | 1 | Pulse on a game-port read or write |
| kbdIrqEvt | input | 1 | Pulse on a keyboard interrupt |
| mouseIrqEvt | input | 1 | Pulse on a mouse interrupt |
| kbcForcePin | input | 1 | Keyboard-controller pin, level, synchronous to `clk` |
| irqOut | output | 16 | Interrupt lines, at most one asserted |

## Verification
The counting path is driven with timeout counts in both units. The checks sit on either side of the expiring tick, so an off-by-one in the counter or in the divide-by-60 prescaler shows up. The random phase mixes sparse ticks with activity pulses under every enable combination and every interrupt code. This separates sources that reload the counter from sources that are masked, and a correct code from codes 0 and 2, which map to no line. Directed cases hold the pin high across a clear, reset each domain on its own, and write the command bits, to separate edge detection from level sensing and the two reset scopes from each other.

// File: rtl/evt_wdt_pkg.sv
package evt_wdt_pkg;
  localparam int REG_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_VALUE = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CFG   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTL   = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_UNIT  = 2'd3;

  // bit positions inside the control register
  localparam int CTL_FLAG  = 0;
  localparam int CTL_FORCE = 2;
  localparam int CTL_PINEN = 3;

  // interrupt-line code that must drive nothing
  localparam int INVALID_CODE = 2;

  typedef struct packed {
    logic reload;    // load counter from loadVal, restart prescaler
    logic forceEvt;  // force timeout: counter to zero
  } wdtStrobe_t;
endpackage

// File: rtl/evt_wdt_ctrl.sv
module evt_wdt_ctrl
  import evt_wdt_pkg::*;
#(
  parameter int IRQ_LINES = 16,
  localparam int CODE_W = $clog2(IRQ_LINES)
) (
  input  logic              clk,
  input  logic              mainRstN,
  input  logic              standbyRstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              gamePortAccess,
  input  logic              kbdIrqEvt,
  input  logic              mouseIrqEvt,
  input  logic              kbcForcePin,
  input  logic              expirePulse,
  output wdtStrobe_t        strobe,
  output logic [REG_W-1:0]  loadVal,
  output logic              secMode,
  output logic              statusFlag,
  output logic [CODE_W-1:0] irqCode
);
  logic [REG_W-1:0] valueReg;
  logic [REG_W-1:0] cfgReg;
  logic             pinEn;
  logic             pinQ;

  logic wrVal, wrCfg, wrCtl, wrUnit;
  logic pinRise, activity, forceEvt, clearReq;

  assign wrVal  = regWrEn && (regAddr == ADDR_VALUE);
  assign wrCfg  = regWrEn && (regAddr == ADDR_CFG);
  assign wrCtl  = regWrEn && (regAddr == ADDR_CTL);
  assign wrUnit = regWrEn && (regAddr == ADDR_UNIT);

  // main-domain registers
  always_ff @(posedge clk or negedge mainRstN) begin
    if (!mainRstN) begin
      valueReg <= '0;
      cfgReg   <= '0;
      secMode  <= 1'b0;
    end else begin
      if (wrVal)  valueReg <= regWrData;
      if (wrCfg)  cfgReg   <= regWrData & ~REG_W'(8'h08);
      if (wrUnit) secMode  <= regWrData[REG_W-1];
    end
  end

  assign pinRise  = kbcForcePin && !pinQ;
  assign activity = (gamePortAccess && cfgReg[0]) ||
                    (kbdIrqEvt && cfgReg[1]) ||
                    (mouseIrqEvt && cfgReg[2]);
  assign forceEvt = (wrCtl && (regWrData[CTL_FORCE] || regWrData[CTL_FLAG])) ||
                    (pinEn && pinRise);
  assign clearReq = (wrCtl && !regWrData[CTL_FLAG]) ||
                    (wrVal && (regWrData != '0));

  always_comb begin
    strobe.forceEvt = forceEvt;
    strobe.reload   = !forceEvt &&
                      ((wrCtl && !regWrData[CTL_FLAG]) || wrVal ||
                       (activity && !statusFlag));
    loadVal = wrVal ? regWrData : valueReg;
  end

  // standby-domain registers
  always_ff @(posedge clk or negedge standbyRstN) begin
    if (!standbyRstN) begin
      statusFlag <= 1'b0;
      pinEn      <= 1'b0;
      pinQ       <= 1'b0;
    end else begin
      pinQ <= kbcForcePin;
      if (wrCtl) pinEn <= regWrData[CTL_PINEN];
      if (forceEvt || expirePulse) statusFlag <= 1'b1;
      else if (clearReq)           statusFlag <= 1'b0;
    end
  end

  assign irqCode = cfgReg[REG_W-1 -: CODE_W];

  always_comb begin
    unique case (regAddr)
      ADDR_VALUE: regRdData = valueReg;
      ADDR_CFG:   regRdData = cfgReg;
      ADDR_CTL: begin
        regRdData = '0;
        regRdData[CTL_FLAG]  = statusFlag;
        regRdData[CTL_PINEN] = pinEn;
      end
      default: begin
        regRdData = '0;
        regRdData[REG_W-1] = secMode;
      end
    endcase
  end
endmodule

// File: rtl/evt_wdt_count.sv
module evt_wdt_count
  import evt_wdt_pkg::*;
#(
  parameter int TICKS_PER_UNIT = 60,
  localparam int PRE_W = (TICKS_PER_UNIT > 1) ? $clog2(TICKS_PER_UNIT) : 1
) (
  input  logic             clk,
  input  logic             mainRstN,
  input  logic             secTick,
  input  logic             secMode,
  input  wdtStrobe_t       strobe,
  input  logic [REG_W-1:0] loadVal,
  output logic [REG_W-1:0] cntVal,
  output logic             expirePulse
);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_UNIT - 1);

  logic [PRE_W-1:0] preCnt;
  logic             unitTick;

  assign unitTick = secTick && (secMode || (preCnt == PRE_LAST));
  assign expirePulse = unitTick && (cntVal == REG_W'(1)) &&
                       !strobe.forceEvt && !strobe.reload;

  always_ff @(posedge clk or negedge mainRstN) begin
    if (!mainRstN) begin
      cntVal <= '0;
      preCnt <= '0;
    end else if (strobe.forceEvt) begin
      cntVal <= '0;
      preCnt <= '0;
    end else if (strobe.reload) begin
      cntVal <= loadVal;
      preCnt <= '0;
    end else begin
      if (secTick && !secMode)
        preCnt <= (preCnt == PRE_LAST) ? '0 : preCnt + PRE_W'(1);
      if (unitTick && (cntVal != '0))
        cntVal <= cntVal - REG_W'(1);
    end
  end
endmodule

// File: rtl/evt_wdt_irqmap.sv
module evt_wdt_irqmap
  import evt_wdt_pkg::*;
#(
  parameter int IRQ_LINES = 16,
  localparam int CODE_W = $clog2(IRQ_LINES)
) (
  input  logic                 statusFlag,
  input  logic [CODE_W-1:0]    irqCode,
  output logic [IRQ_LINES-1:0] irqOut
);
  for (genvar k = 0; k < IRQ_LINES; k++) begin : gLine
    if (k == 0 || k == INVALID_CODE) begin : gNone
      assign irqOut[k] = 1'b0;
    end else begin : gDrive
      assign irqOut[k] = statusFlag && (irqCode == CODE_W'(k));
    end
  end
endmodule

// File: rtl/evt_watchdog.sv
module evt_watchdog
  import evt_wdt_pkg::*;
#(
  parameter int TICKS_PER_UNIT = 60,
  parameter int IRQ_LINES = 16
) (
  input  logic                 clk,
  input  logic                 mainRstN,
  input  logic                 standbyRstN,
  input  logic                 secTick,
  input  logic                 regWrEn,
  input  logic [1:0]           regAddr,
  input  logic [7:0]           regWrData,
  output logic [7:0]           regRdData,
  input  logic                 gamePortAccess,
  input  logic                 kbdIrqEvt,
  input  logic                 mouseIrqEvt,
  input  logic                 kbcForcePin,
  output logic [IRQ_LINES-1:0] irqOut
);
  localparam int CODE_W = $clog2(IRQ_LINES);

  wdtStrobe_t        strobe;
  logic [REG_W-1:0]  loadVal;
  logic [REG_W-1:0]  cntVal;
  logic              secMode;
  logic              statusFlag;
  logic              expirePulse;
  logic [CODE_W-1:0] irqCode;

  evt_wdt_ctrl #(.IRQ_LINES(IRQ_LINES)) uCtrl (
    .clk(clk), .mainRstN(mainRstN), .standbyRstN(standbyRstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .gamePortAccess(gamePortAccess),
    .kbdIrqEvt(kbdIrqEvt), .mouseIrqEvt(mouseIrqEvt),
    .kbcForcePin(kbcForcePin), .expirePulse(expirePulse),
    .strobe(strobe), .loadVal(loadVal), .secMode(secMode),
    .statusFlag(statusFlag), .irqCode(irqCode)
  );

  evt_wdt_count #(.TICKS_PER_UNIT(TICKS_PER_UNIT)) uCount (
    .clk(clk), .mainRstN(mainRstN), .secTick(secTick), .secMode(secMode),
    .strobe(strobe), .loadVal(loadVal), .cntVal(cntVal),
    .expirePulse(expirePulse)
  );

  evt_wdt_irqmap #(.IRQ_LINES(IRQ_LINES)) uIrq (
    .statusFlag(statusFlag), .irqCode(irqCode), .irqOut(irqOut)
  );
endmodule

// File: rtl/evt_wdt_checker.sv
module evt_wdt_checker #(
  parameter int IRQ_LINES = 16
) (
  input logic                 clk,
  input logic                 mainRstN,
  input logic                 standbyRstN,
  input logic                 regWrEn,
  input logic [1:0]           regAddr,
  input logic [7:0]           regWrData,
  input logic                 kbcForcePin,
  input logic [IRQ_LINES-1:0] irqOut,
  input logic                 statusFlag,
  input logic [7:0]           cntVal
);
  AST_IRQ_ONEHOT: assert property (@(posedge clk) disable iff (!mainRstN || !standbyRstN)
    $onehot0(irqOut)); // R6
  AST_IRQ_NO_RESERVED: assert property (@(posedge clk) disable iff (!mainRstN || !standbyRstN)
    !irqOut[0] && !irqOut[2]); // R6
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!mainRstN || !standbyRstN)
    (irqOut != '0) |-> statusFlag); // R6
  AST_HALT_AT_ZERO: assert property (@(posedge clk) disable iff (!mainRstN || !standbyRstN)
    statusFlag |-> (cntVal == 8'd0)); // R2
  AST_SW_FORCE: assert property (@(posedge clk) disable iff (!mainRstN || !standbyRstN)
    (regWrEn && regAddr == 2'd2 && regWrData[2]) |=> statusFlag); // R8
  AST_CLEAR_WRITE: assert property (@(posedge clk) disable iff (!mainRstN || !standbyRstN)
    (regWrEn && regAddr == 2'd2 && regWrData[2:0] == 3'b000 && !kbcForcePin)
      |=> !statusFlag); // R7
  AST_VALUE_LOAD: assert property (@(posedge clk) disable iff (!mainRstN || !standbyRstN)
    (regWrEn && regAddr == 2'd0 && regWrData != 8'd0 && !kbcForcePin)
      |=> (!statusFlag && cntVal == $past(regWrData))); // R11
endmodule

bind evt_watchdog evt_wdt_checker #(.IRQ_LINES(IRQ_LINES)) uChk (
  .clk(clk), .mainRstN(mainRstN), .standbyRstN(standbyRstN),
  .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
  .kbcForcePin(kbcForcePin), .irqOut(irqOut),
  .statusFlag(statusFlag), .cntVal(cntVal)
);

// File: tb/evt_watchdog_test.sv
`timescale 1ns/1ps
module evt_watchdog_test;
  logic clk = 1'b0;
  logic mainRstN = 1'b0, standbyRstN = 1'b0;
  logic secTick = 1'b0, regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic gamePortAccess = 1'b0, kbdIrqEvt = 1'b0, mouseIrqEvt = 1'b0, kbcForcePin = 1'b0;
  logic [15:0] irqOut;

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  evt_watchdog uut (
    .clk(clk), .mainRstN(mainRstN), .standbyRstN(standbyRstN), .secTick(secTick),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .gamePortAccess(gamePortAccess), .kbdIrqEvt(kbdIrqEvt), .mouseIrqEvt(mouseIrqEvt),
    .kbcForcePin(kbcForcePin), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    regAddr = a;
    #0.5;
    d = regRdData;
  endtask

  task automatic tickN(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); secTick = 1'b1;
      @(negedge clk); secTick = 1'b0;
    end
  endtask

  task automatic flagIs(input string req, input logic exp);
    logic [7:0] d;
    rd(2'd2, d);
    chk(req, d[0], exp);
  endtask

  function automatic logic [15:0] expIrq(input logic [3:0] code, input logic st);
    if (!st || code == 4'd0 || code == 4'd2) return 16'h0;
    return 16'h1 << code;
  endfunction

  initial begin
    #500000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    mainRstN = 1'b1; standbyRstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      chk("R1 reg after reset", d, 8'h00);
    end
    chk("R1 irq after reset", irqOut, 16'h0);

    // R12 reserved bits
    wr(2'd1, 8'hFF); rd(2'd1, d); chk("R12 cfg bit3 reads 0", d, 8'hF7);
    wr(2'd3, 8'hFF); rd(2'd3, d); chk("R12 unit reg bit7 only", d, 8'h80);
    wr(2'd2, 8'hFF); rd(2'd2, d); chk("R12 ctl readback", d, 8'h09);
    chk("R6 code 15 line", irqOut, 16'h8000);
    wr(2'd2, 8'h00);

    // R2 seconds mode, IRQ3
    wr(2'd1, 8'h30);
    wr(2'd0, 8'd5);
    tickN(4); flagIs("R2 before Nth tick", 1'b0);
    chk("R6 no line while counting", irqOut, 16'h0);
    tickN(1); flagIs("R2 at Nth tick", 1'b1);
    chk("R6 IRQ3 asserted", irqOut, 16'h0008);
    tickN(3); flagIs("R2 flag holds", 1'b1);

    // R7 clear and restart
    wr(2'd2, 8'h00); flagIs("R7 flag cleared", 1'b0);
    chk("R7 irq dropped", irqOut, 16'h0);
    tickN(4); flagIs("R7 restarted count", 1'b0);
    tickN(1); flagIs("R7 expires again", 1'b1);

    // R6 code 2 and code 0 drive nothing
    wr(2'd1, 8'h20); chk("R6 code 2 no line", irqOut, 16'h0);
    wr(2'd1, 8'h00); chk("R6 code 0 no line", irqOut, 16'h0);
    wr(2'd1, 8'h10); chk("R6 code 1 line", irqOut, 16'h0002);

    // R11 nonzero value write clears flag
    wr(2'd0, 8'd4); flagIs("R11 flag cleared", 1'b0);
    rd(2'd0, d); chk("R11 value readback", d, 8'd4);
    tickN(3); flagIs("R11 loaded 4 not expired", 1'b0);
    tickN(1); flagIs("R11 loaded 4 expired", 1'b1);

    // R3 minute mode, count 2 -> 120 ticks
    wr(2'd3, 8'h00);
    wr(2'd0, 8'd2);
    tickN(119); flagIs("R3 before 120th tick", 1'b0);
    tickN(1); flagIs("R3 at 120th tick", 1'b1);

    // R4 count 0 disables
    wr(2'd3, 8'h80);
    wr(2'd0, 8'd0); wr(2'd2, 8'h00);
    tickN(300); flagIs("R4 disabled no expiry", 1'b0);

    // R5 keyboard enabled reloads, mouse disabled ignored
    wr(2'd1, 8'h02);
    wr(2'd0, 8'd3);
    tickN(2);
    @(negedge clk); kbdIrqEvt = 1'b1; @(negedge clk); kbdIrqEvt = 1'b0;
    tickN(2); flagIs("R5 kbd reload", 1'b0);
    tickN(1); flagIs("R5 kbd reload expiry", 1'b1);
    wr(2'd0, 8'd3);
    tickN(2);
    @(negedge clk); mouseIrqEvt = 1'b1; @(negedge clk); mouseIrqEvt = 1'b0;
    tickN(1); flagIs("R5 mouse masked", 1'b1);

    // R8 software force
    wr(2'd2, 8'h00);
    wr(2'd2, 8'h04); rd(2'd2, d); chk("R8 forced, bit2 reads 0", d, 8'h01);

    // R9 pin force
    wr(2'd2, 8'h08); flagIs("R9 cleared before pin", 1'b0);
    @(negedge clk); kbcForcePin = 1'b1;
    @(negedge clk); flagIs("R9 pin edge forces", 1'b1);
    wr(2'd2, 8'h08);
    repeat (5) @(negedge clk);
    flagIs("R9 held pin no refire", 1'b0);
    kbcForcePin = 1'b0;
    wr(2'd2, 8'h00);
    @(negedge clk); kbcForcePin = 1'b1;
    repeat (2) @(negedge clk);
    flagIs("R9 disabled pin ignored", 1'b0);
    kbcForcePin = 1'b0;

    // R10 reset domains
    wr(2'd0, 8'h33); wr(2'd1, 8'h40);
    wr(2'd2, 8'h08); wr(2'd2, 8'h0C);
    @(negedge clk); mainRstN = 1'b0; @(negedge clk); mainRstN = 1'b1;
    rd(2'd0, d); chk("R10 main clears value", d, 8'h00);
    rd(2'd1, d); chk("R10 main clears cfg", d, 8'h00);
    rd(2'd2, d); chk("R10 main keeps ctl", d, 8'h09);
    @(negedge clk); standbyRstN = 1'b0; @(negedge clk); standbyRstN = 1'b1;
    rd(2'd2, d); chk("R10 standby clears ctl", d, 8'h00);

    // random: seconds mode, activity reload R5 and line mapping R6
    wr(2'd3, 8'h80);
    for (int r = 0; r < 20; r++) begin
      logic [7:0] val; logic [2:0] en; logic [3:0] code;
      logic [7:0] mCnt; logic mStat;
      val  = 8'($urandom_range(1, 6));
      en   = 3'($urandom_range(0, 7));
      code = 4'($urandom_range(0, 15));
      wr(2'd1, {code, 1'b0, en});
      wr(2'd0, val);
      mCnt = val; mStat = 1'b0;
      for (int c = 0; c < 50; c++) begin
        logic tk, gp, kb, ms, act;
        flagIs("R5 random flag", mStat);
        chk("R6 random line", irqOut, expIrq(code, mStat));
        tk = ($urandom_range(0, 2) == 0);
        gp = ($urandom_range(0, 15) == 0);
        kb = ($urandom_range(0, 15) == 0);
        ms = ($urandom_range(0, 15) == 0);
        secTick = tk; gamePortAccess = gp; kbdIrqEvt = kb; mouseIrqEvt = ms;
        act = (gp && en[0]) || (kb && en[1]) || (ms && en[2]);
        if (!mStat) begin
          if (act) mCnt = val;
          else if (tk && mCnt != 0) begin
            mCnt = mCnt - 8'd1;
            if (mCnt == 0) mStat = 1'b1;
          end
        end
        @(negedge clk);
        secTick = 1'b0; gamePortAccess = 1'b0; kbdIrqEvt = 1'b0; mouseIrqEvt = 1'b0;
      end
      wr(2'd2, 8'h00);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule